// File: doc/BRIEF.md
# Laser Light Presence Interlock

This block turns four raw light-detect bits, one per wavelength of a four-wavelength external continuous-wave laser feed, into four active-low light-present pins. The laser source uses these pins as an eye-safety interlock. Each raw bit passes through a two-flop synchronizer. A lane then counts as qualified only after its detection has stayed high over a programmable number of millisecond ticks.

A pin is driven low only while all four lanes are qualified. The same condition is reported as an active-high summary. Loss of light on any lane clears that lane's qualification at once, without waiting for a tick. All pins therefore return high within a few clock cycles, which is well inside the one-millisecond bound. In reset every pin reads high, which is the laser-disabled state that a board pull-up gives when the module is absent.

Lane index 0 to 3 maps to 1271, 1291, 1311 and 1331 nm.

Top module: `light_interlock`

## Requirements
- R1: While rst_n is low, present_n reads 4'b1111 and all_present reads 0.
- R2: When a raw detect bit falls with no tick, present_n becomes 4'b1111 and all_present 0 at the third rising edge after the fall, and not before.
- R3: With qual_ticks = N (N >= 1) and a lane's synchronized detect held high, the lane qualifies at the clock edge of the N-th tick. After N-1 ticks it is still unqualified.
- R4: A qual_ticks value of 0 behaves as 1: a single tick qualifies the lane.
- R5: Any low on a lane's synchronized detect clears that lane's tick count, so the full N ticks must be seen again.
- R6: A bit of present_n (bit i for lane i) is low only when all four lanes are qualified. all_present is 1 exactly when present_n is 4'b0000.
- R7: Without ms_tick pulses, no lane qualifies, however long light stays present.
- R8: A qualified lane stays qualified while another lane loses light. Once the lost lane requalifies, the pins go low without the others counting again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| light_raw | input | 4 | Raw light-detect bits, one per lane, asynchronous |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| qual_ticks | input | 8 | Number of ticks of stable light needed to qualify a lane |
| present_n | output | 4 | Active-low light-present pins, one per laser |
| all_present | output | 1 | High when all four lanes are qualified |

## Verification
A lane whose qualification flag is stuck or whose counter fails to restart shows up as pins that go low one tick early or one tick late. A lane that never clears shows up as pins staying low past the third edge after light is lost. Either fault is visible at the ports within one tick period or within three clock cycles. Wrong gating across lanes appears as a pin low while another lane is dark, as soon as the lanes disagree.

// File: rtl/light_interlock_pkg.sv
package light_interlock_pkg;
  localparam int LANES = 4;
  localparam int CNT_W = 8;

  // Tick count actually required; zero is treated as one.
  function automatic logic [CNT_W-1:0] qual_target(input logic [CNT_W-1:0] q);
    return (q == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : q;
  endfunction

  // True when the tick now arriving completes qualification.
  function automatic logic tick_completes(input logic [CNT_W-1:0] cnt,
                                          input logic [CNT_W-1:0] q);
    logic [CNT_W:0] nxt;
    nxt = {1'b0, cnt} + 1'b1;
    return nxt >= {1'b0, qual_target(q)};
  endfunction
endpackage

// File: rtl/li_sync2.sv
module li_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      d_sync <= '0;
    end else begin
      stage1 <= d_async;
      d_sync <= stage1;
    end
  end
endmodule

// File: rtl/li_lane_qual.sv
module li_lane_qual
  import light_interlock_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             det,
  input  logic             tick,
  input  logic [CNT_W-1:0] qual_ticks,
  output logic             qualified
);
  logic [CNT_W-1:0] cnt;
  logic             done_now;

  assign done_now = tick && det && !qualified && tick_completes(cnt, qual_ticks);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      qualified <= 1'b0;
    end else if (!det) begin
      cnt       <= '0;
      qualified <= 1'b0;
    end else if (done_now) begin
      qualified <= 1'b1;
    end else if (tick && !qualified) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2
  loss_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !det |=> !qualified);
  // R5
  count_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !det |=> cnt == '0);
  // R7
  rise_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qualified) |-> $past(tick) && $past(det));
endmodule

// File: rtl/light_interlock.sv
module light_interlock
  import light_interlock_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] light_raw,
  input  logic             ms_tick,
  input  logic [CNT_W-1:0] qual_ticks,
  output logic [LANES-1:0] present_n,
  output logic             all_present
);
  logic [LANES-1:0] det_sync;
  logic [LANES-1:0] lane_ok;

  li_sync2 #(.W(LANES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(light_raw),
    .d_sync (det_sync)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    li_lane_qual u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .det       (det_sync[i]),
      .tick      (ms_tick),
      .qual_ticks(qual_ticks),
      .qualified (lane_ok[i])
    );
  end

  assign all_present = &lane_ok;
  assign present_n   = ~({LANES{all_present}} & lane_ok);

  // R1
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reset_safe_chk: assert (&present_n && !all_present);
    end
  end
  // R6
  summary_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_present |-> present_n == '0);
  // R6
  partial_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !all_present |-> &present_n);
  // R2
  dark_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (det_sync != '1) |=> &present_n);
endmodule

// File: tb/light_interlock_test.sv
module light_interlock_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] light_raw = 4'h0;
  logic       ms_tick = 1'b0;
  logic [7:0] qual_ticks = 8'd3;
  logic [3:0] present_n;
  logic       all_present;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  light_interlock uut (
    .clk(clk), .rst_n(rst_n), .light_raw(light_raw), .ms_tick(ms_tick),
    .qual_ticks(qual_ticks), .present_n(present_n), .all_present(all_present)
  );

  task automatic check(string tag, logic [3:0] pins_exp, logic all_exp);
    n_checks++;
    if (present_n !== pins_exp || all_present !== all_exp) begin
      n_fail++;
      $display("FAIL %s: present_n=%b all_present=%b expected %b %b",
               tag, present_n, all_present, pins_exp, all_exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) ms_tick = 1'b1;
    @(negedge clk) ms_tick = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; light_raw = 4'h0; ms_tick = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset", 4'hF, 1'b0);
    light_raw = 4'hF;
    repeat (3) @(negedge clk);
    check("R1 reset with light", 4'hF, 1'b0);
    rst_n = 1'b1; light_raw = 4'h0;
    @(negedge clk);
  endtask

  task automatic t_qualify();
    do_reset(); qual_ticks = 8'd3;
    light_raw = 4'hF; settle();
    tick(); tick();
    check("R3 after N-1 ticks", 4'hF, 1'b0);
    tick();
    check("R3 after N ticks", 4'h0, 1'b1);
  endtask

  task automatic t_loss();
    @(negedge clk) light_raw = 4'b1011;
    @(negedge clk);
    @(negedge clk);
    check("R2 two edges after loss", 4'h0, 1'b1);
    @(negedge clk);
    check("R2 third edge after loss", 4'hF, 1'b0);
  endtask

  task automatic t_requalify();
    light_raw = 4'hF; settle();
    tick(); tick();
    check("R8 lost lane not yet back", 4'hF, 1'b0);
    tick();
    check("R8 lost lane back", 4'h0, 1'b1);
  endtask

  task automatic t_partial();
    do_reset(); qual_ticks = 8'd3;
    light_raw = 4'b0111; settle();
    repeat (5) tick();
    check("R6 three lanes lit", 4'hF, 1'b0);
    light_raw = 4'hF; settle();
    tick(); tick();
    check("R6 fourth lane counting", 4'hF, 1'b0);
    tick();
    check("R8 others held while fourth qualified", 4'h0, 1'b1);
  endtask

  task automatic t_no_tick();
    do_reset(); qual_ticks = 8'd1;
    light_raw = 4'hF;
    repeat (200) @(negedge clk);
    check("R7 no ticks", 4'hF, 1'b0);
  endtask

  task automatic t_glitch();
    do_reset(); qual_ticks = 8'd3;
    light_raw = 4'hF; settle();
    tick(); tick();
    @(negedge clk) light_raw = 4'b1110;
    repeat (3) @(negedge clk);
    light_raw = 4'hF; settle();
    tick(); tick();
    check("R5 restarted lane after two ticks", 4'hF, 1'b0);
    tick();
    check("R5 restarted lane after three ticks", 4'h0, 1'b1);
  endtask

  task automatic t_zero();
    do_reset(); qual_ticks = 8'd0;
    light_raw = 4'hF; settle();
    check("R4 before tick", 4'hF, 1'b0);
    tick();
    check("R4 one tick", 4'h0, 1'b1);
    @(negedge clk) light_raw = 4'h0;
    repeat (3) @(negedge clk);
    check("R2 all lanes dark", 4'hF, 1'b0);
  endtask

  initial begin
    t_qualify();
    t_loss();
    t_requalify();
    t_partial();
    t_no_tick();
    t_glitch();
    t_zero();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule